// File: doc/BRIEF.md
# Configuration Window Access Router

This block sits between a memory-style request port and the configuration register files of up to 32 function slots on the first bus. It checks whether each request address lies inside a fixed configuration window. Inside the window it splits the offset from the window base into bus, slot, function and register fields. If the request reaches a real target, it forwards the request to that slot through a one-hot select. Slot 0 always holds the host bridge and counts as populated whatever the present vector says. The other slots are populated according to a present vector.

Read replies come back a fixed single cycle after the request, through a valid strobe. A request that misses the window, names a bus other than 0, names a nonzero function, names an empty slot, or runs past the end of the 4 KiB register space reaches no slot. Such a read returns all-ones, and such a write is dropped without any trace.

Top module: `cfgr_router`

## Requirements
- R1: The window is the half-open range [WIN_BASE, WIN_BASE+WIN_SIZE), checked without wraparound. The address WIN_BASE is accepted. WIN_BASE-1 and WIN_BASE+WIN_SIZE miss the window.
- R2: With offset = address - WIN_BASE, the register field is offset[11:0] and is presented on cfgReg. The slot is offset[19:15] and the function is offset[14:12].
- R3: An access whose bus field offset[27:20] is nonzero reaches no slot. A read of it returns 0xFFFFFFFF.
- R4: An access whose function field is nonzero reaches no slot. A read of it returns 0xFFFFFFFF.
- R5: An access to a slot whose slotPresent bit is 0 reaches no slot, and a read of it returns 0xFFFFFFFF. Slot 0 is always treated as present.
- R6: A read accepted in cycle N raises rspValid for exactly cycle N+1. In that cycle rspData holds the 32-bit word of slotRdata from the selected slot (bits [32*s+31:32*s]), sampled in cycle N. Back-to-back reads give back-to-back replies.
- R7: A read that misses the window returns rspValid one cycle later with rspData = 0xFFFFFFFF.
- R8: A write to a valid target raises the one-hot cfgSel bit of that slot in the request cycle, with cfgWrite = 1 and cfgWdata = reqWdata. A write to an invalid target raises no cfgSel bit. No write ever raises rspValid.
- R9: reqSize encodes the access width (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes). An access where register + width > 4096 is invalid, and a read of it returns 0xFFFFFFFF.
- R10: During and after reset, with no request, rspValid is 0 and cfgSel is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | A request is present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Access width code |
| reqAddr | input | ADDR_W | Physical request address |
| reqWdata | input | 32 | Write data |
| slotPresent | input | NUM_SLOTS | Populated slots (bit 0 ignored, forced present) |
| slotRdata | input | 32*NUM_SLOTS | Read word from each slot for the presented register |
| cfgSel | output | NUM_SLOTS | One-hot slot select for a valid access |
| cfgWrite | output | 1 | Forwarded direction |
| cfgSize | output | 2 | Forwarded width code |
| cfgReg | output | 12 | Register offset within the slot |
| cfgWdata | output | 32 | Forwarded write data |
| rspValid | output | 1 | Read reply valid |
| rspData | output | 32 | Read reply data |

## Verification
Addresses are placed just below the window, at its base, at its upper limit and just beyond it. This separates the lower and upper bound comparisons. Requests inside the window then vary one field at a time: bus, function, slot presence and register offset near the 4 KiB end. This shows that each rejection condition acts alone and that a valid access selects exactly the decoded slot with the decoded register. Reads and writes go to the same targets, which distinguishes forwarding from replying. Back-to-back reads, including a hit followed by a miss, show that each reply carries the data of its own request.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  // Decoded request fields
  typedef struct packed {
    logic        inWin;
    logic [7:0]  bus;
    logic [4:0]  slot;
    logic [2:0]  func;
    logic [11:0] regOff;
  } cfgrFields_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic fwd;       // request goes to a real slot
    logic rdAccept;  // read accepted, capture a reply
  } cfgrStrobes_t;

  function automatic logic [2:0] accessBytes(input logic [1:0] code);
    case (code)
      2'd0:    accessBytes = 3'd1;
      2'd1:    accessBytes = 3'd2;
      default: accessBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/cfgr_datapath.sv
module cfgr_datapath
  import cfgr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_SLOTS = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hE000_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0200_0000,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic                    reqWrite,
  input  logic [1:0]              reqSize,
  input  logic [31:0]             reqWdata,
  input  logic [32*NUM_SLOTS-1:0] slotRdata,
  input  cfgrStrobes_t            stb,
  output cfgrFields_t             fields,
  output logic [NUM_SLOTS-1:0]    cfgSel,
  output logic                    cfgWrite,
  output logic [1:0]              cfgSize,
  output logic [11:0]             cfgReg,
  output logic [31:0]             cfgWdata,
  output logic [31:0]             rspData
);

  logic [ADDR_W-1:0] offset;
  logic              aboveBase;
  logic [31:0]       slotWords [NUM_SLOTS];

  // Subtract only after the lower bound holds, so the compare never wraps
  assign aboveBase = (reqAddr >= WIN_BASE);
  assign offset    = reqAddr - WIN_BASE;

  always_comb begin
    fields.inWin  = aboveBase && (offset < WIN_SIZE);
    fields.bus    = offset[27:20];
    fields.slot   = offset[19:15];
    fields.func   = offset[14:12];
    fields.regOff = offset[11:0];
  end

  assign cfgWrite = reqWrite;
  assign cfgSize  = reqSize;
  assign cfgReg   = fields.regOff;
  assign cfgWdata = reqWdata;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign slotWords[i] = slotRdata[32*i +: 32];
    assign cfgSel[i]    = stb.fwd && (fields.slot == 5'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData <= '0;
    end else if (stb.rdAccept) begin
      rspData <= stb.fwd ? slotWords[fields.slot[SLOT_W-1:0]] : '1;
    end
  end

  // R8: at most one slot is selected
  a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cfgSel));

endmodule

// File: rtl/cfgr_ctrl.sv
module cfgr_ctrl
  import cfgr_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int REG_SPACE = 4096
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [1:0]           reqSize,
  input  cfgrFields_t          fields,
  input  logic [NUM_SLOTS-1:0] slotPresent,
  output cfgrStrobes_t         stb,
  output logic                 rspValid
);

  logic [NUM_SLOTS-1:0] presentEff;
  logic                 slotOk;
  logic [12:0]          regEnd;
  logic                 overrun;

  always_comb begin
    presentEff    = slotPresent;
    presentEff[0] = 1'b1;  // host bridge always there
  end

  assign slotOk  = ({1'b0, fields.slot} < 6'(NUM_SLOTS)) &&
                   presentEff[fields.slot[SLOT_W-1:0]];
  assign regEnd  = {1'b0, fields.regOff} + 13'(accessBytes(reqSize));
  assign overrun = (regEnd > 13'(REG_SPACE));

  always_comb begin
    stb.fwd      = reqValid && fields.inWin && (fields.bus == 8'd0) &&
                   (fields.func == 3'd0) && slotOk && !overrun;
    stb.rdAccept = reqValid && !reqWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= stb.rdAccept;
  end

  // R8: writes never produce a reply
  a_r8_write_silent: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> !rspValid);

  // R6: a reply only follows a request
  a_r6_reply_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid));

endmodule

// File: rtl/cfgr_router.sv
module cfgr_router
  import cfgr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_SLOTS = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hE000_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0200_0000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [1:0]              reqSize,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [31:0]             reqWdata,
  input  logic [NUM_SLOTS-1:0]    slotPresent,
  input  logic [32*NUM_SLOTS-1:0] slotRdata,
  output logic [NUM_SLOTS-1:0]    cfgSel,
  output logic                    cfgWrite,
  output logic [1:0]              cfgSize,
  output logic [11:0]             cfgReg,
  output logic [31:0]             cfgWdata,
  output logic                    rspValid,
  output logic [31:0]             rspData
);

  cfgrFields_t  fields;
  cfgrStrobes_t stb;

  cfgr_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .fields(fields), .slotPresent(slotPresent),
    .stb(stb), .rspValid(rspValid)
  );

  cfgr_datapath #(
    .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS),
    .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqWdata(reqWdata), .slotRdata(slotRdata),
    .stb(stb), .fields(fields), .cfgSel(cfgSel), .cfgWrite(cfgWrite),
    .cfgSize(cfgSize), .cfgReg(cfgReg), .cfgWdata(cfgWdata),
    .rspData(rspData)
  );

  // R7: a reply with no forwarded request carries all-ones
  a_r7_miss_all_ones: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !$past(stb.fwd)) |-> (rspData == 32'hFFFF_FFFF));

  // R5: only populated slots (slot 0 always) are ever selected
  a_r5_sel_present: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgSel & ~(slotPresent | NUM_SLOTS'(1))) == '0));

  // R10: no select without a request
  a_r10_sel_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    (|cfgSel) |-> reqValid);

endmodule

// File: tb/cfgr_router_test.sv
`timescale 1ns/1ps
module cfgr_router_test;

  localparam int NS = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqWrite = 1'b0;
  logic [1:0]      reqSize = 2'd2;
  logic [31:0]     reqAddr = '0;
  logic [31:0]     reqWdata = '0;
  logic [NS-1:0]   slotPresent = 32'h0000_0016;  // slots 1,2,4; bit0 clear
  logic [32*NS-1:0] slotRdata;
  logic [NS-1:0]   cfgSel;
  logic            cfgWrite;
  logic [1:0]      cfgSize;
  logic [11:0]     cfgReg;
  logic [31:0]     cfgWdata;
  logic            rspValid;
  logic [31:0]     rspData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cfgr_router uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .slotPresent(slotPresent), .slotRdata(slotRdata), .cfgSel(cfgSel),
    .cfgWrite(cfgWrite), .cfgSize(cfgSize), .cfgReg(cfgReg),
    .cfgWdata(cfgWdata), .rspValid(rspValid), .rspData(rspData)
  );

  function automatic logic [31:0] slotWord(input int s);
    return 32'hC0DE_0000 | 32'(s);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [1:0]  size;
    logic        hit;
    logic [4:0]  slot;
    logic [11:0] regOff;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'hE000_0000, 2'd2, 1'b1, 5'd0,  12'h000},  // R1 base, R5 slot0 forced
    '{1'b0, 32'hDFFF_FFFF, 2'd0, 1'b0, 5'd0,  12'h000},  // R1 below
    '{1'b0, 32'hE200_0000, 2'd2, 1'b0, 5'd0,  12'h000},  // R1 base+size
    '{1'b0, 32'hE1FF_FFFC, 2'd2, 1'b0, 5'd0,  12'h000},  // R3 last bus in window
    '{1'b0, 32'hE010_0000, 2'd2, 1'b0, 5'd0,  12'h000},  // R3 bus 1
    '{1'b0, 32'hE000_1000, 2'd2, 1'b0, 5'd0,  12'h000},  // R4 func 1
    '{1'b0, 32'hE000_80AC, 2'd2, 1'b1, 5'd1,  12'h0AC},  // R2 slot1 reg 0AC
    '{1'b0, 32'hE001_8000, 2'd2, 1'b0, 5'd0,  12'h000},  // R5 slot3 absent
    '{1'b0, 32'hE002_0004, 2'd2, 1'b1, 5'd4,  12'h004},  // R2 slot4
    '{1'b0, 32'hE00F_8000, 2'd2, 1'b0, 5'd0,  12'h000},  // R5 slot31 absent
    '{1'b0, 32'hE000_0FFE, 2'd2, 1'b0, 5'd0,  12'h000},  // R9 overrun
    '{1'b0, 32'hE000_0FFE, 2'd1, 1'b1, 5'd0,  12'hFFE},  // R9 fits
    '{1'b0, 32'hE000_0FFF, 2'd0, 1'b1, 5'd0,  12'hFFF},  // R9 last byte
    '{1'b1, 32'hE001_0004, 2'd2, 1'b1, 5'd2,  12'h004},  // R8 valid write
    '{1'b1, 32'hE001_8004, 2'd2, 1'b0, 5'd0,  12'h000},  // R8 absent write
    '{1'b1, 32'hE200_0000, 2'd2, 1'b0, 5'd0,  12'h000}   // R8 out-of-window write
  };

  initial begin
    for (int i = 0; i < NS; i++) slotRdata[32*i +: 32] = slotWord(i);
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 rspValid in reset", 32'(rspValid), 32'd0);
    check("R10 cfgSel in reset", cfgSel, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 rspValid idle", 32'(rspValid), 32'd0);
    check("R10 cfgSel idle", cfgSel, 32'd0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      reqValid = 1'b1;
      reqWrite = VECS[v].wr;
      reqAddr  = VECS[v].addr;
      reqSize  = VECS[v].size;
      reqWdata = 32'h5A00_0000 | 32'(v);
      #1;
      check($sformatf("R2/R8 vec%0d cfgSel", v), cfgSel,
            VECS[v].hit ? (32'd1 << VECS[v].slot) : 32'd0);
      if (VECS[v].hit) begin
        check($sformatf("R2 vec%0d cfgReg", v), 32'(cfgReg), 32'(VECS[v].regOff));
        check($sformatf("R8 vec%0d cfgWrite", v), 32'(cfgWrite), 32'(VECS[v].wr));
        if (VECS[v].wr)
          check($sformatf("R8 vec%0d cfgWdata", v), cfgWdata, 32'h5A00_0000 | 32'(v));
      end
      @(negedge clk);
      reqValid = 1'b0;
      check($sformatf("R6/R8 vec%0d rspValid", v), 32'(rspValid), 32'(!VECS[v].wr));
      if (!VECS[v].wr)
        check($sformatf("R6/R7 vec%0d rspData", v), rspData,
              VECS[v].hit ? slotWord(int'(VECS[v].slot)) : 32'hFFFF_FFFF);
    end

    // R6: back-to-back reads, hit then miss
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqSize = 2'd2;
    reqAddr = 32'hE001_0000;  // slot 2
    @(negedge clk);
    check("R6 b2b first valid", 32'(rspValid), 32'd1);
    check("R6 b2b first data", rspData, slotWord(2));
    reqAddr = 32'hE000_9000;  // slot1 func1 -> miss
    @(negedge clk);
    reqValid = 1'b0;
    check("R6 b2b second valid", 32'(rspValid), 32'd1);
    check("R4 b2b second data", rspData, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R6 single-cycle pulse", 32'(rspValid), 32'd0);

    // R5: populate slot 3, now it is reached
    slotPresent = 32'h0000_001E;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'hE001_8000;
    #1;
    check("R5 slot3 now present sel", cfgSel, 32'h0000_0008);
    @(negedge clk);
    reqValid = 1'b0;
    check("R5 slot3 now present data", rspData, slotWord(3));
    #1;
    check("R10 cfgSel drops with reqValid", cfgSel, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule